// File: doc/BRIEF.md
# Bi-Quinary Decade Counter

This block is a four-bit counter made of two independent sections. The first is a divide-by-two stage with its own count input. The second is a divide-by-five section of three bits with a separate count input. Both count inputs are asynchronous levels. The block samples them on one system clock, and each section advances once for every high-to-low transition that it detects on its own input.

Two pairs of gated control inputs act on the clock. When both inputs of the clear pair are high, the counter goes to zero. When both inputs of the preset pair are high, the counter loads nine. The preset wins over the clear.

A mode input chains the two sections inside the block, so no external wiring or combinational loop is needed:
- BCD mode counts 0 to 9 from input A.
- Bi-quinary mode counts from input B and gives a symmetrical divide-by-ten square wave on bit 0.

Top module: `bq_decade_counter`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0000. After reset, `q_o` stays 0000 until a control input or a count edge acts.
- R2: In separate mode, each falling edge on `cnt_a_i` inverts `q_o[0]`. The input is driven between clock edges and then held. The new value appears at the third rising clock edge after the fall, and not before that edge.
- R3: In separate mode, each falling edge on `cnt_b_i` steps `q_o[3:1]` through 000, 001, 010, 011, 100 and then back to 000. The codes 101, 110 and 111 never appear.
- R4: When `clr_a_i` and `clr_b_i` are both high and the preset pair is not both high, `q_o` is 0000 after the next rising clock edge.
- R5: When `nine_a_i` and `nine_b_i` are both high, `q_o` is 1001 after the next rising clock edge, whatever the clear inputs are.
- R6: A count edge that is detected while a full clear or a full preset is applied is lost. With only one input of a pair high, counting goes on unchanged.
- R7: Rising edges on a count input and a steady level on it leave `q_o` unchanged.
- R8: In BCD mode (`mode_i`=1), falling edges on `cnt_a_i` step `q_o` through 0 to 9 and then back to 0. `cnt_b_i` is ignored in this mode.
- R9: In bi-quinary mode (`mode_i`=2), falling edges on `cnt_b_i` drive the five-state section. `q_o[0]` inverts each time that section wraps from 100 to 000. After n edges from zero, `q_o[0]` is (n/5) mod 2. `cnt_a_i` is ignored in this mode.
- R10: The mode encoding is 0 for separate sections, 1 for BCD and 2 for bi-quinary. Code 3 behaves as separate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_i | input | 1 | Count input of the divide-by-two section |
| cnt_b_i | input | 1 | Count input of the divide-by-five section |
| mode_i | input | 2 | Chaining mode: 0 separate, 1 BCD, 2 bi-quinary, 3 separate |
| clr_a_i | input | 1 | First input of the gated clear |
| clr_b_i | input | 1 | Second input of the gated clear |
| nine_a_i | input | 1 | First input of the gated preset-to-nine |
| nine_b_i | input | 1 | Second input of the gated preset-to-nine |
| q_o | output | 4 | Count value: [3:1] five-state section, [0] divide-by-two section |

## Verification
The assertions check the following on every cycle:
- the clear and preset results one cycle after a full control pair;
- the toggle and modulo-five step of each section whenever its internal advance fires, and holding otherwise;
- that the five-state section never leaves 000 to 100.

The bench scenarios cover what the assertions cannot see. These are the three-edge latency from a pin fall, the ignored pin in each chained mode, the full BCD and bi-quinary sequences, and a sweep over all sixteen control-pin combinations with edges applied.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_BCD   = 2'd1,
    MODE_BIQ   = 2'd2,
    MODE_ALT   = 2'd3
  } bq_mode_e;

  localparam int QUIN_MOD   = 5;
  localparam int QUIN_WIDTH = $clog2(QUIN_MOD);
endpackage

// File: rtl/bq_fall_detect.sv
module bq_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] shift_q;
  logic [LAST:0] shift_d;

  // stage 0 samples the pin; the top stage holds the previous settled sample
  generate
    if (LAST == 0) begin : g_single
      always_comb shift_d = din;
    end else begin : g_chain
      always_comb shift_d = {shift_q[LAST-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  generate
    if (LAST == 0) begin : g_fall_single
      assign fall_o = 1'b0;
    end else begin : g_fall_chain
      assign fall_o = shift_q[LAST] & ~shift_q[LAST-1];
    end
  endgenerate
endmodule

// File: rtl/bq_div2.sv
module bq_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic load_zero,
  input  logic load_nine,
  input  logic adv,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = load_nine | load_zero | adv;
    if (load_nine)      q_d = 1'b1;
    else if (load_zero) q_d = 1'b0;
    else                q_d = ~q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/bq_divn.sv
module bq_divn #(
  parameter int MODULUS = 5,
  parameter int WIDTH   = $clog2(MODULUS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_zero,
  input  logic             load_nine,
  input  logic             adv,
  output logic [WIDTH-1:0] q,
  output logic             at_top
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] q_d;
  logic             q_en;

  assign at_top = (q == TOP);

  always_comb begin
    q_en = load_nine | load_zero | adv;
    if (load_nine)      q_d = TOP;
    else if (load_zero) q_d = '0;
    else if (q >= TOP)  q_d = '0;   // wrap, and any unused code folds to zero
    else                q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
  import bq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_a_i,
  input  logic       cnt_b_i,
  input  logic [1:0] mode_i,
  input  logic       clr_a_i,
  input  logic       clr_b_i,
  input  logic       nine_a_i,
  input  logic       nine_b_i,
  output logic [3:0] q_o
);
  logic fall_a, fall_b;
  logic ctl_nine, ctl_zero, ctl_hold;
  logic adv_a, adv_b;
  logic qa;
  logic [QUIN_WIDTH-1:0] qq;
  logic quin_top;
  bq_mode_e mode;

  assign mode = bq_mode_e'(mode_i);

  bq_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge_a (
    .clk(clk), .rst_n(rst_n), .din(cnt_a_i), .fall_o(fall_a));
  bq_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge_b (
    .clk(clk), .rst_n(rst_n), .din(cnt_b_i), .fall_o(fall_b));

  always_comb begin
    ctl_nine = nine_a_i & nine_b_i;
    ctl_zero = clr_a_i & clr_b_i & ~ctl_nine;
    ctl_hold = ctl_nine | (clr_a_i & clr_b_i);
  end

  // chained modes feed one section's carry straight into the other's advance
  always_comb begin
    unique case (mode)
      MODE_BCD: begin
        adv_a = fall_a;
        adv_b = fall_a & qa;
      end
      MODE_BIQ: begin
        adv_b = fall_b;
        adv_a = fall_b & quin_top;
      end
      default: begin
        adv_a = fall_a;
        adv_b = fall_b;
      end
    endcase
    adv_a = adv_a & ~ctl_hold;
    adv_b = adv_b & ~ctl_hold;
  end

  bq_div2 u_bin (
    .clk(clk), .rst_n(rst_n), .load_zero(ctl_zero), .load_nine(ctl_nine),
    .adv(adv_a), .q(qa));

  bq_divn #(.MODULUS(QUIN_MOD), .WIDTH(QUIN_WIDTH)) u_quin (
    .clk(clk), .rst_n(rst_n), .load_zero(ctl_zero), .load_nine(ctl_nine),
    .adv(adv_b), .q(qq), .at_top(quin_top));

  assign q_o = {qq, qa};
endmodule

// File: rtl/bq_decade_counter_chk.sv
module bq_decade_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_a_i,
  input logic       clr_b_i,
  input logic       nine_a_i,
  input logic       nine_b_i,
  input logic       adv_a,
  input logic       adv_b,
  input logic [3:0] q_o
);
  logic full_nine, full_clr, idle;
  assign full_nine = nine_a_i & nine_b_i;
  assign full_clr  = clr_a_i & clr_b_i & ~full_nine;
  assign idle      = ~full_nine & ~(clr_a_i & clr_b_i);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_clr |=> (q_o == 4'b0000));

  assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_nine |=> (q_o == 4'b1001));

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && adv_a) |=> (q_o[0] != $past(q_o[0])));

  assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !adv_a) |=> $stable(q_o[0]));

  assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !adv_b) |=> $stable(q_o[3:1]));

  assert_quin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && adv_b && q_o[3:1] != 3'd4) |=> (q_o[3:1] == $past(q_o[3:1]) + 3'd1));

  assert_quin_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && adv_b && q_o[3:1] == 3'd4) |=> (q_o[3:1] == 3'd0));

  assert_quin_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_o[3:1] <= 3'd4);

  assert_value_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_o <= 4'd9);
endmodule

bind bq_decade_counter bq_decade_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
  .nine_a_i(nine_a_i), .nine_b_i(nine_b_i), .adv_a(adv_a), .adv_b(adv_b),
  .q_o(q_o));

// File: tb/tb_bq_decade_counter.sv
module tb_bq_decade_counter;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_a_i, cnt_b_i;
  logic [1:0] mode_i;
  logic       clr_a_i, clr_b_i, nine_a_i, nine_b_i;
  logic [3:0] q_o;

  int checks = 0;
  int failures = 0;
  int ra;  // model of bit 0
  int rb;  // model of five-state section

  always #(CLK_PERIOD/2) clk = ~clk;

  bq_decade_counter dut (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a_i), .cnt_b_i(cnt_b_i),
    .mode_i(mode_i), .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
    .nine_a_i(nine_a_i), .nine_b_i(nine_b_i), .q_o(q_o));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model();
    return {3'(rb), 1'(ra)};
  endfunction

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fall_a();
    @(negedge clk); cnt_a_i = 1'b0; waitn(4);
    cnt_a_i = 1'b1; waitn(4);
  endtask

  task automatic fall_b();
    @(negedge clk); cnt_b_i = 1'b0; waitn(4);
    cnt_b_i = 1'b1; waitn(4);
  endtask

  task automatic set_ctl(input logic [3:0] c);
    @(negedge clk);
    {clr_a_i, clr_b_i, nine_a_i, nine_b_i} = c;
    waitn(2);
  endtask

  task automatic zero_all();
    set_ctl(4'b1100); set_ctl(4'b0000);
    ra = 0; rb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_a_i = 1'b1; cnt_b_i = 1'b1; mode_i = 2'd0;
    {clr_a_i, clr_b_i, nine_a_i, nine_b_i} = 4'b0000;
    ra = 0; rb = 0;
    waitn(3);
    check("R1 in reset", q_o, 4'b0000);
    rst_n = 1'b1;
    waitn(6);
    check("R1 after reset idle", q_o, 4'b0000);

    // R2 latency: three rising edges from the fall
    @(negedge clk); cnt_a_i = 1'b0;
    waitn(2); check("R2 before third edge", q_o, 4'b0000);
    waitn(1); check("R2 at third edge", q_o, 4'b0001);
    ra = 1;
    waitn(3);
    // R7 rising edge and level have no effect
    cnt_a_i = 1'b1; waitn(6);
    check("R7 rising edge ignored", q_o, model());

    // R2 and R3 separate mode sweeps
    for (int n = 0; n < 6; n++) begin
      fall_a(); ra ^= 1;
      check("R2 toggle", q_o, model());
    end
    for (int n = 0; n < 12; n++) begin
      fall_b(); rb = (rb + 1) % 5;
      check("R3 five-state step", q_o, model());
    end

    // R4, R5, R6 sweep over all control combinations with edges applied
    for (int c = 0; c < 16; c++) begin
      logic nine_full, clr_full;
      zero_all();
      fall_b(); rb = 1;
      nine_full = (c[1] && c[0]);
      clr_full  = (c[3] && c[2]);
      @(negedge clk);
      {clr_a_i, clr_b_i, nine_a_i, nine_b_i} = 4'(c);
      fall_a(); fall_b();
      if (nine_full)     begin ra = 1; rb = 4; end
      else if (clr_full) begin ra = 0; rb = 0; end
      else               begin ra ^= 1; rb = (rb + 1) % 5; end
      check(nine_full ? "R5 preset priority" : (clr_full ? "R4 clear" : "R6 partial pair counts"),
            q_o, model());
      set_ctl(4'b0000);
      check("R6 edges during hold lost", q_o, model());
    end

    // R8 BCD mode
    zero_all();
    mode_i = 2'd1;
    for (int n = 1; n <= 23; n++) begin
      fall_a();
      check("R8 BCD count", q_o, 4'(n % 10));
    end
    fall_b();
    check("R8 pin B ignored", q_o, 4'(23 % 10));

    // R9 bi-quinary mode
    zero_all();
    mode_i = 2'd2;
    for (int n = 1; n <= 22; n++) begin
      fall_b();
      check("R9 biquinary", q_o, {3'(n % 5), 1'((n / 5) % 2)});
    end
    fall_a();
    check("R9 pin A ignored", q_o, {3'(22 % 5), 1'((22 / 5) % 2)});

    // R10 mode code 3 behaves as separate
    zero_all();
    mode_i = 2'd3;
    fall_a(); ra = 1;
    check("R10 code3 A alone", q_o, model());
    fall_a(); ra = 0;
    check("R10 code3 A no carry", q_o, model());
    fall_b(); rb = 1;
    check("R10 code3 B alone", q_o, model());

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule